// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This block is a real-time clock peripheral that sits on a simple 32-bit register bus. A prescaler divides the system clock into a one-cycle tick per second. On each tick, a 32-bit seconds counter advances by one. Software can preset the counter to any value and program a match value. When the counter reaches the match value, an alarm flag is raised. The alarm can be masked, read and cleared. The alarm drives one level interrupt output.

The bus uses a single-cycle strobe: a select, a write flag, a word address within a 4 KB window and the write data. Read data is combinational from the address while select is high and write is low. Eight identification bytes, one per word, occupy the top of the window.

Top module: `rtc_match_alarm`

## Requirements
- R1: After reset the count, match, mask and raw status all read 0, and `alarm_irq` is 0.
- R2: The count rises by exactly 1 every `TICK_DIV` clock cycles. A write to the load register (offset 0x08) restarts the prescaler. After k clock edges following that write, the count reads V + floor(k / `TICK_DIV`), where V is the loaded value.
- R3: A write to the load register sets the count to the written value. Counting wraps modulo 2^32, so 0xFFFFFFFF is followed by 0. The data register at offset 0x00 returns the count.
- R4: The match register at offset 0x04 reads back the written value. The raw status flag (bit 0 of offset 0x14) becomes 1 on the tick that moves the count onto the match value.
- R5: A write to the match register or to the load register sets the raw flag at once if the resulting count equals the resulting match value.
- R6: The mask register (offset 0x10) stores only bit 0 of the written data. It reads back as that single bit.
- R7: Any write to the clear register (offset 0x1C) clears the raw flag, whatever data is written.
- R8: `alarm_irq` and the masked status read (offset 0x18) both equal raw AND mask.
- R9: The control register (offset 0x0C) always reads 1. Writes to it are ignored.
- R10: Writes to offsets 0x00, 0x14 and 0x18 have no effect. A read of offset 0x1C returns 0. Reads of unmapped offsets return 0.
- R11: Reads from offsets 0xFE0 to 0xFFC return one byte per word, indexed by (offset − 0xFE0) >> 2. The bytes in order are 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_sel` is high and `bus_wr` is low |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
The bench builds the block with `TICK_DIV` = 4. With that setting, a full second lasts four cycles, so every cycle of the counter's progress after a load can be swept and predicted arithmetically. The bench loads several start values, including the two values just below the wrap point. It then reads the count on each of thirteen consecutive edges, which covers three full ticks and the wrap from 0xFFFFFFFF to 0. The short second also lets the bench reach the tick-driven alarm within a few cycles, and test immediate firing, masking and clearing between ticks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_COUNT = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_MATCH = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_LOAD  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_MSKD  = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_CLEAR = 12'h01C;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    id_byte = 8'h31;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h14;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICK_DIV = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: a tick lasts exactly one cycle
  a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && TICK_DIV > 1) |=> !tick);
endmodule

// File: rtl/rtc_core.sv
module rtc_core #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_load,
  input  logic              wr_match,
  input  logic              wr_mask,
  input  logic              wr_clear,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] match,
  output logic              mask,
  output logic              raw
);
  logic [DATA_W-1:0] count_q, count_d;
  logic [DATA_W-1:0] match_q, match_d;
  logic              mask_q, mask_d;
  logic              raw_q, raw_d;
  logic              evt, hit;

  always_comb begin
    if (wr_load)   count_d = wdata;
    else if (tick) count_d = count_q + 1'b1;
    else           count_d = count_q;
    match_d = wr_match ? wdata : match_q;
    mask_d  = wr_mask ? wdata[0] : mask_q;
    evt     = tick | wr_load | wr_match;
    hit     = evt && (count_d == match_d);
    if (hit)           raw_d = 1'b1;
    else if (wr_clear) raw_d = 1'b0;
    else               raw_d = raw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      match_q <= '0;
      mask_q  <= 1'b0;
      raw_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      match_q <= match_d;
      mask_q  <= mask_d;
      raw_q   <= raw_d;
    end
  end

  assign count = count_q;
  assign match = match_q;
  assign mask  = mask_q;
  assign raw   = raw_q;

  // R2: without a load the count holds or steps by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_load |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1));
  // R3: load takes the written value
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> count_q == $past(wdata));
  // R5: a match write equal to a steady count fires at once
  a_r5_match_now: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_match && !tick && wdata == count_q) |=> raw_q);
  // R6: mask keeps bit 0 only
  a_r6_mask_bit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> mask_q == $past(wdata[0]));
  // R7: clear drops the flag unless a new hit lands in the same cycle
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clear |=> !raw_q || (count_q == match_q));
endmodule

// File: rtl/rtc_regread.sv
module rtc_regread #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] count,
  input  logic [DATA_W-1:0] match,
  input  logic              mask,
  input  logic              raw,
  output logic [DATA_W-1:0] rdata
);
  import rtc_pkg::*;

  logic in_id;
  assign in_id = (addr[ADDR_W-1:5] == '1);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (in_id) begin
        rdata = DATA_W'(id_byte(addr[4:2]));
      end else begin
        case ({addr[ADDR_W-1:2], 2'b00})
          OFS_COUNT: rdata = count;
          OFS_MATCH: rdata = match;
          OFS_CTRL:  rdata = DATA_W'(1);
          OFS_MASK:  rdata = DATA_W'(mask);
          OFS_RAW:   rdata = DATA_W'(raw);
          OFS_MSKD:  rdata = DATA_W'(raw & mask);
          default:   rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtc_match_alarm.sv
module rtc_match_alarm #(
  parameter int unsigned TICK_DIV = 50_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        alarm_irq
);
  import rtc_pkg::*;

  logic              rst_sync_n;
  logic              tick;
  logic              wr_en, rd_en;
  logic              wr_load, wr_match, wr_mask, wr_clear;
  logic [ADDR_W-1:0] word_addr;
  logic [DATA_W-1:0] count, match;
  logic              mask, raw;

  assign wr_en     = bus_sel & bus_wr;
  assign rd_en     = bus_sel & ~bus_wr;
  assign word_addr = {bus_addr[ADDR_W-1:2], 2'b00};
  assign wr_load   = wr_en && (word_addr == OFS_LOAD);
  assign wr_match  = wr_en && (word_addr == OFS_MATCH);
  assign wr_mask   = wr_en && (word_addr == OFS_MASK);
  assign wr_clear  = wr_en && (word_addr == OFS_CLEAR);

  rtc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  rtc_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .restart(wr_load), .tick(tick)
  );

  rtc_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick),
    .wr_load(wr_load), .wr_match(wr_match), .wr_mask(wr_mask),
    .wr_clear(wr_clear), .wdata(bus_wdata),
    .count(count), .match(match), .mask(mask), .raw(raw)
  );

  rtc_regread #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .rd_en(rd_en), .addr(bus_addr), .count(count), .match(match),
    .mask(mask), .raw(raw), .rdata(bus_rdata)
  );

  assign alarm_irq = raw & mask;

  // R8: interrupt agrees with the masked status read
  a_r8_irq_vs_read: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && word_addr == OFS_MSKD) |-> bus_rdata[0] == alarm_irq);
  // R9: control always reads enabled
  a_r9_ctrl_one: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && word_addr == OFS_CTRL) |-> bus_rdata == 32'd1);
endmodule

// File: tb/sim_rtc_match_alarm.sv
module sim_rtc_match_alarm;
  localparam int DIV = 4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        alarm_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_match_alarm #(.TICK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alarm_irq(alarm_irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  // combinational read within the low phase, no edge consumed
  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] starts [6];
    starts = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h1234_5678};
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(12'h000, v); check("R1 count", v, 0);
    rd(12'h004, v); check("R1 match", v, 0);
    rd(12'h010, v); check("R1 mask", v, 0);
    rd(12'h014, v); check("R1 raw", v, 0);
    check("R1 irq", {31'd0, alarm_irq}, 0);

    // R2/R3 sweep of count progress after loads, including wrap
    wr(12'h004, 32'hDEAD_0000);
    for (int s = 0; s < 6; s++) begin
      wr(12'h008, starts[s]);
      for (int k = 0; k <= 12; k++) begin
        rd(12'h000, v);
        check("R2 R3 count step", v, starts[s] + 32'(k / DIV));
        @(negedge clk);
      end
    end
    wr(12'h01C, 0);

    // R4 tick-driven alarm
    wr(12'h004, 32'h100);
    rd(12'h004, v); check("R4 match readback", v, 32'h100);
    wr(12'h008, 32'hFE);
    for (int k = 0; k <= 9; k++) begin
      rd(12'h014, v); check("R4 raw on reach", v, (k >= 8) ? 1 : 0);
      check("R8 irq masked off", {31'd0, alarm_irq}, 0);
      @(negedge clk);
    end
    // R6 mask bit 0 only
    wr(12'h010, 32'hFFFF_FFFE);
    rd(12'h010, v); check("R6 mask even", v, 0);
    rd(12'h018, v); check("R8 masked read 0", v, 0);
    wr(12'h010, 32'h3);
    rd(12'h010, v); check("R6 mask odd", v, 1);
    check("R8 irq on", {31'd0, alarm_irq}, 1);
    rd(12'h018, v); check("R8 masked read 1", v, 1);
    // R10 writes to status registers ignored
    wr(12'h014, 0); wr(12'h018, 0);
    rd(12'h014, v); check("R10 raw unchanged", v, 1);
    // R7 clear with zero data
    wr(12'h01C, 0);
    rd(12'h014, v); check("R7 raw cleared", v, 0);
    check("R7 irq cleared", {31'd0, alarm_irq}, 0);
    rd(12'h018, v); check("R8 masked after clear", v, 0);

    // R5 immediate fire on match write, then on load write
    wr(12'h008, 32'h55);
    wr(12'h004, 32'h55);
    rd(12'h014, v); check("R5 fire on match write", v, 1);
    wr(12'h01C, 32'hFFFF_FFFF);
    rd(12'h014, v); check("R7 clear any data", v, 0);
    wr(12'h004, 32'h99);
    wr(12'h008, 32'h99);
    rd(12'h014, v); check("R5 fire on load write", v, 1);
    wr(12'h01C, 0);

    // R9 control
    rd(12'h00C, v); check("R9 ctrl reads 1", v, 1);
    wr(12'h00C, 0);
    rd(12'h00C, v); check("R9 ctrl after write", v, 1);

    // R10 data write ignored, clear reads 0, unmapped reads 0
    wr(12'h008, 32'h40);
    wr(12'h000, 32'h1234);
    rd(12'h000, v); check("R10 data write ignored", v, 32'h40);
    rd(12'h01C, v); check("R10 clear reads 0", v, 0);
    rd(12'h020, v); check("R10 unmapped 020", v, 0);
    rd(12'h800, v); check("R10 unmapped 800", v, 0);
    rd(12'hFDC, v); check("R10 unmapped FDC", v, 0);

    // R11 identification bytes
    for (int i = 0; i < 8; i++) begin
      logic [7:0] e;
      case (i)
        0: e = 8'h31; 1: e = 8'h10; 2: e = 8'h14; 3: e = 8'h00;
        4: e = 8'h0D; 5: e = 8'hF0; 6: e = 8'h05; default: e = 8'hB1;
      endcase
      rd(12'hFE0 + 12'(i * 4), v); check("R11 id byte", v, {24'd0, e});
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule